// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Unit

This unit sits beside a FIFO's storage and turns its fill count into two early-warning flags. It keeps two offsets. The lower offset is measured up from the empty end, and the upper offset is measured down from the full end. The lower flag is raised while few enough words remain. The upper flag is raised while few enough free slots remain. The storage and its pointers are not part of this unit. It only reads the word count that the FIFO reports.

Both offsets are written either as whole words from the data bus or one bit at a time from a single-bit input. The level of the load pin while master reset is held selects two things: the default offset pair and which of the two writing methods is accepted. Software can read the offsets back over the output bus whichever method is active. Partial reset clears only the write and read-back sequencing. It keeps the offsets and the chosen method, so a FIFO can be flushed without programming them again.

Read-back is a one-way stream with a valid qualifier (`rb_valid`) and no ready. Every cycle in which read-back is requested produces exactly one result word one cycle later. The receiver must take it in that cycle, because the unit does not hold or repeat it. The write-side inputs take no back-pressure either: every qualifying edge is consumed.

Top module: `afo_unit`

## Requirements
- R1: While `mrst_n` is low with `ld` low at a clock edge, both offsets become 127 and parallel writing is selected.
- R2: While `mrst_n` is low with `ld` high at a clock edge, both offsets become 1023 and serial writing is selected.
- R3: In parallel mode, each edge with `ld` and `wr_en` high stores `din[OFS_W-1:0]`. The first such edge writes the lower (almost-empty) offset, the next writes the upper (almost-full) offset, and further edges keep alternating.
- R4: In serial mode, each edge with `ld` and `ser_en` high shifts `ser_in` into the offset pair. After 2*OFS_W such edges, the first bit sent sits in bit 0 of the lower offset and the last bit sent sits in the top bit of the upper offset. Bits therefore go least significant first, lower offset before upper.
- R5: An edge with `ld` and `rb_en` high drives, one cycle later, `rb_valid` high and `rb_data` equal to an offset zero-extended. The order is lower offset first, then upper, then alternating. `rb_valid` is low in every other cycle.
- R6: Dropping `ld` for one edge returns both the parallel-write sequence and the read-back sequence to the lower offset.
- R7: A low `prst_n` leaves both offsets and the selected writing method unchanged, and returns both sequences to the lower offset.
- R8: `almost_empty` is high exactly when `fill_cnt` is less than or equal to the lower offset.
- R9: `almost_full` is high exactly when `fill_cnt` is greater than or equal to DEPTH minus the upper offset.
- R10: Writes through the method that is not selected leave both offsets unchanged: `wr_en` in serial mode, `ser_en` in parallel mode.
- R11: With `ld` low, `wr_en` and `ser_en` leave both offsets unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low, synchronous |
| ld | input | 1 | Offset access select; sampled for defaults during master reset |
| wr_en | input | 1 | Parallel write strobe |
| ser_en | input | 1 | Serial write strobe |
| ser_in | input | 1 | Serial offset bit |
| rb_en | input | 1 | Read-back request |
| din | input | DATA_W | Parallel offset data |
| fill_cnt | input | CNT_W | Current FIFO word count, 0 to DEPTH |
| rb_data | output | DATA_W | Read-back offset, zero-extended |
| rb_valid | output | 1 | Read-back word valid this cycle |
| almost_empty | output | 1 | Count at or below lower offset |
| almost_full | output | 1 | Count at or above DEPTH minus upper offset |

## Verification
The offsets are written with patterns whose two values differ. This shows whether a write landed in the lower or the upper offset, and whether the sequence wrapped or restarted after `ld` dropped or after a partial reset. A single-word write, and a wrong-method attempt made in each mode, separate a real write from one that was correctly ignored. The serial pattern uses uneven bit values in both offsets, so a reversed bit order or swapped offsets would read back wrong. The fill count is then stepped across each threshold one below and at the boundary, and also at 0 and at DEPTH, so that an off-by-one comparison shows up in both flags.

// File: rtl/afo_pkg.sv
package afo_pkg;
  typedef enum logic {
    SEL_LOWER = 1'b0,
    SEL_UPPER = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/afo_ofs_regs.sv
module afo_ofs_regs
  import afo_pkg::*;
#(
  parameter int OFS_W   = 12,
  parameter int DATA_W  = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld,
  input  logic              wr_en,
  input  logic              ser_en,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] din,
  output logic [OFS_W-1:0]  lo_ofs,
  output logic [OFS_W-1:0]  hi_ofs,
  output logic              ser_mode
);
  localparam logic [OFS_W-1:0] PAR_DEFAULT = OFS_W'(DEF_PAR);
  localparam logic [OFS_W-1:0] SER_DEFAULT = OFS_W'(DEF_SER);

  ofs_sel_e wsel;

  // Serial path: the pair {hi,lo} acts as one shift register filled from the top,
  // so the first bit shifted ends at lo[0] after 2*OFS_W edges.
  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ser_mode <= ld;
      lo_ofs   <= ld ? SER_DEFAULT : PAR_DEFAULT;
      hi_ofs   <= ld ? SER_DEFAULT : PAR_DEFAULT;
      wsel     <= SEL_LOWER;
    end else if (!prst_n || !ld) begin
      wsel <= SEL_LOWER;
    end else if (ser_mode) begin
      if (ser_en) begin
        {hi_ofs, lo_ofs} <= {ser_in, hi_ofs, lo_ofs[OFS_W-1:1]};
      end
    end else if (wr_en) begin
      if (wsel == SEL_LOWER) begin
        lo_ofs <= din[OFS_W-1:0];
        wsel   <= SEL_UPPER;
      end else begin
        hi_ofs <= din[OFS_W-1:0];
        wsel   <= SEL_LOWER;
      end
    end
  end
endmodule

// File: rtl/afo_readback.sv
module afo_readback
  import afo_pkg::*;
#(
  parameter int OFS_W  = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              ld,
  input  logic              rb_en,
  input  logic [OFS_W-1:0]  lo_ofs,
  input  logic [OFS_W-1:0]  hi_ofs,
  output logic [DATA_W-1:0] rb_data,
  output logic              rb_valid
);
  ofs_sel_e rsel;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      rsel     <= SEL_LOWER;
      rb_valid <= 1'b0;
      rb_data  <= '0;
    end else if (!prst_n || !ld) begin
      rsel     <= SEL_LOWER;
      rb_valid <= 1'b0;
    end else begin
      rb_valid <= rb_en;
      if (rb_en) begin
        rb_data <= DATA_W'((rsel == SEL_LOWER) ? lo_ofs : hi_ofs);
        rsel    <= (rsel == SEL_LOWER) ? SEL_UPPER : SEL_LOWER;
      end
    end
  end
endmodule

// File: rtl/afo_thresh.sv
module afo_thresh #(
  parameter int CNT_W     = 13,
  parameter int OFS_W     = 12,
  parameter int DEPTH     = 4096,
  parameter bit FROM_FULL = 1'b0
) (
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic [OFS_W-1:0] ofs,
  output logic             flag
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  generate
    if (FROM_FULL) begin : g_upper
      logic [CNT_W-1:0] limit;
      assign limit = FULL_CNT - CNT_W'(ofs);
      assign flag  = (fill_cnt >= limit);
    end else begin : g_lower
      assign flag = (fill_cnt <= CNT_W'(ofs));
    end
  endgenerate
endmodule

// File: rtl/afo_unit.sv
module afo_unit #(
  parameter int DEPTH   = 4096,
  parameter int DATA_W  = 16,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic                         clk,
  input  logic                         mrst_n,
  input  logic                         prst_n,
  input  logic                         ld,
  input  logic                         wr_en,
  input  logic                         ser_en,
  input  logic                         ser_in,
  input  logic                         rb_en,
  input  logic [DATA_W-1:0]            din,
  input  logic [$clog2(DEPTH+1)-1:0]   fill_cnt,
  output logic [DATA_W-1:0]            rb_data,
  output logic                         rb_valid,
  output logic                         almost_empty,
  output logic                         almost_full
);
  localparam int OFS_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [OFS_W-1:0] lo_ofs;
  logic [OFS_W-1:0] hi_ofs;
  logic             ser_mode;

  afo_ofs_regs #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) u_regs (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld),
    .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
    .lo_ofs(lo_ofs), .hi_ofs(hi_ofs), .ser_mode(ser_mode)
  );

  afo_readback #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_rb (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .rb_en(rb_en),
    .lo_ofs(lo_ofs), .hi_ofs(hi_ofs), .rb_data(rb_data), .rb_valid(rb_valid)
  );

  afo_thresh #(.CNT_W(CNT_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .FROM_FULL(1'b0)) u_lo (
    .fill_cnt(fill_cnt), .ofs(lo_ofs), .flag(almost_empty)
  );

  afo_thresh #(.CNT_W(CNT_W), .OFS_W(OFS_W), .DEPTH(DEPTH), .FROM_FULL(1'b1)) u_hi (
    .fill_cnt(fill_cnt), .ofs(hi_ofs), .flag(almost_full)
  );
endmodule

// File: rtl/afo_unit_chk.sv
module afo_unit_chk #(
  parameter int DEPTH = 4096,
  parameter int OFS_W = 12,
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             prst_n,
  input logic             ld,
  input logic             wr_en,
  input logic             ser_en,
  input logic             rb_en,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             rb_valid,
  input logic             almost_empty,
  input logic             almost_full,
  input logic [OFS_W-1:0] lo_ofs,
  input logic [OFS_W-1:0] hi_ofs,
  input logic             ser_mode
);
  assert_rb_valid_after_req_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && ld && rb_en) |=> rb_valid);

  assert_rb_valid_idle_R5: assert property (@(posedge clk) disable iff (!mrst_n)
    !(prst_n && ld && rb_en) |=> !rb_valid);

  assert_prst_keeps_offsets_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    !prst_n |=> (lo_ofs == $past(lo_ofs)) && (hi_ofs == $past(hi_ofs)) && (ser_mode == $past(ser_mode)));

  assert_empty_count_flags_R8: assert property (@(posedge clk) disable iff (!mrst_n)
    (fill_cnt == '0) |-> almost_empty);

  assert_full_count_flags_R9: assert property (@(posedge clk) disable iff (!mrst_n)
    (fill_cnt == CNT_W'(DEPTH)) |-> almost_full);

  assert_wrong_method_R10: assert property (@(posedge clk) disable iff (!mrst_n)
    (prst_n && ld && ((ser_mode && wr_en && !ser_en) || (!ser_mode && ser_en && !wr_en)))
    |=> ($stable(lo_ofs) && $stable(hi_ofs)));

  assert_no_load_without_ld_R11: assert property (@(posedge clk) disable iff (!mrst_n)
    !ld |=> ($stable(lo_ofs) && $stable(hi_ofs)));
endmodule

bind afo_unit afo_unit_chk #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wr_en(wr_en),
  .ser_en(ser_en), .rb_en(rb_en), .fill_cnt(fill_cnt), .rb_valid(rb_valid),
  .almost_empty(almost_empty), .almost_full(almost_full),
  .lo_ofs(lo_ofs), .hi_ofs(hi_ofs), .ser_mode(ser_mode)
);

// File: tb/test_afo_unit.sv
module test_afo_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4096;
  localparam int DATA_W = 16;
  localparam int OFS_W  = 12;
  localparam int CNT_W  = 13;

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, ld = 1'b0, wr_en = 1'b0;
  logic ser_en = 1'b0, ser_in = 1'b0, rb_en = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [CNT_W-1:0]  fill_cnt = '0;
  logic [DATA_W-1:0] rb_data;
  logic rb_valid, almost_empty, almost_full;

  afo_unit #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_afo_unit (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .ld(ld), .wr_en(wr_en),
    .ser_en(ser_en), .ser_in(ser_in), .rb_en(rb_en), .din(din),
    .fill_cnt(fill_cnt), .rb_data(rb_data), .rb_valid(rb_valid),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  int exp_lo, exp_hi, exp_wsel;
  bit exp_ser;
  int exp_q[$];
  string exp_tag[$];

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops one expected word per valid read-back result
  always @(negedge clk) begin
    if (mrst_n && rb_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R5 unexpected rb_valid actual=%0d expected=none", rb_data);
      end else begin
        chk(exp_tag.pop_front(), int'(rb_data), exp_q.pop_front());
      end
    end
  end

  task automatic mreset(bit l);
    @(negedge clk);
    mrst_n = 1'b0; ld = l; wr_en = 0; ser_en = 0; rb_en = 0;
    @(negedge clk); @(negedge clk);
    mrst_n = 1'b1; ld = 1'b0;
    exp_ser = l; exp_lo = l ? 1023 : 127; exp_hi = exp_lo; exp_wsel = 0;
  endtask

  task automatic pword(int d);
    @(negedge clk);
    ld = 1; wr_en = 1; ser_en = 0; din = DATA_W'(d);
    if (!exp_ser) begin
      if (exp_wsel == 0) exp_lo = d % DEPTH; else exp_hi = d % DEPTH;
      exp_wsel ^= 1;
    end
  endtask

  task automatic pend();
    @(negedge clk);
    ld = 0; wr_en = 0; ser_en = 0; rb_en = 0;
    exp_wsel = 0;
  endtask

  task automatic sload(int lo, int hi);
    for (int i = 0; i < 2*OFS_W; i++) begin
      @(negedge clk);
      ld = 1; ser_en = 1; wr_en = 0;
      ser_in = (i < OFS_W) ? lo[i] : hi[i-OFS_W];
    end
    if (exp_ser) begin exp_lo = lo; exp_hi = hi; end
    pend();
  endtask

  task automatic rd(int n, string tag);
    int sel = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld = 1; rb_en = 1; wr_en = 0; ser_en = 0;
      exp_q.push_back(sel == 0 ? exp_lo : exp_hi);
      exp_tag.push_back(tag);
      sel ^= 1;
    end
    pend();
    @(negedge clk);
    chk({tag, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic pulse_prst();
    @(negedge clk);
    prst_n = 0; wr_en = 0; ser_en = 0; rb_en = 0;
    @(negedge clk);
    prst_n = 1;
    exp_wsel = 0;
  endtask

  task automatic flag(int cnt, int ae, int af, string tag);
    @(negedge clk);
    fill_cnt = CNT_W'(cnt);
    #1;
    chk({tag, " almost_empty"}, int'(almost_empty), ae);
    chk({tag, " almost_full"}, int'(almost_full), af);
  endtask

  initial begin
    mreset(1'b0);
    @(negedge clk);
    chk("R5 reset rb_valid", int'(rb_valid), 0);
    flag(0, 1, 0, "R8 reset count 0");
    rd(2, "R1 parallel defaults");

    pword(100); pword(3000); pend();
    rd(3, "R3 R5 lower/upper order");
    pword(5); pword(6); pword(7); pend();
    rd(2, "R3 wrap to lower");

    pword(11); pend(); pword(22); pend();
    rd(2, "R6 ld drop restarts");

    @(negedge clk); ld = 0; wr_en = 1; din = 16'd99;
    @(negedge clk); wr_en = 0;
    rd(2, "R11 no ld no write");
    sload(12'h111, 12'h222);
    rd(2, "R10 serial ignored in parallel mode");

    flag(22, 1, 0, "R8 at lower offset");
    flag(23, 0, 0, "R8 above lower offset");
    flag(4089, 0, 0, "R9 below upper limit");
    flag(4090, 0, 1, "R9 at upper limit");
    flag(DEPTH, 0, 1, "R9 full count");

    pword(33); pulse_prst(); pword(44); pend();
    rd(2, "R7 prst keeps offsets and mode");

    mreset(1'b1);
    rd(2, "R2 serial defaults");
    pword(77); pword(88); pend();
    rd(2, "R10 parallel ignored in serial mode");
    sload(12'h5A3, 12'h0C7);
    rd(3, "R4 serial bit order");
    flag(1443, 1, 0, "R8 serial lower offset");
    flag(1444, 0, 0, "R8 serial above lower");
    flag(3896, 0, 0, "R9 serial below limit");
    flag(3897, 0, 1, "R9 serial at limit");
    pulse_prst();
    rd(2, "R7 prst keeps serial offsets");
    sload(12'h00F, 12'hF00);
    rd(2, "R7 serial mode kept after prst");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule